// File: doc/BRIEF.md
# Real-Time Clock Power-Down and Interrupt Controller

This block sits beside the timekeeping core of a real-time clock and manages two things: the low-power state and the interrupt pin. A low level on the power-down request pin puts the block to sleep. If a bus access is in progress at that moment, entry waits until the access has ended. While asleep, the block tells the bus interface to disregard address and data activity. It also holds the square-wave clock output low and lets the interrupt pin float, so external circuits can read three levels from the pin.

Two sources can raise an interrupt: an alarm match, when the alarm is enabled, and a falling edge of the selected square wave. Each source sets a sticky bit in a two-bit status word. Whenever any bit is set, the interrupt pin is pulled low, both awake and asleep. A status read clears the word but is honoured only while awake. The device reset input also clears the word and returns the pin to its inactive high level. The alarm comparator, the divider chain and the oscillator live outside the block and appear here as plain inputs.

Top module: `rtc_pwrint_ctrl`

## Requirements
- R1: After the synchronous system reset, status_o is 2'b00, int_oe_o is 1 with int_o at 1, bus_ignore_o is 0, and clk_out_o is 1 while no wave is selected.
- R2: With bus_busy_i low, a low pd_n_i sampled at a clock edge sets bus_ignore_o to 1 from that edge onward. It is still 0 in the cycle in which the request is first applied.
- R3: A low pd_n_i applied while bus_busy_i is high leaves bus_ignore_o at 0 for as long as bus_busy_i stays high. Sleep begins at the first edge that samples bus_busy_i low with the request still present.
- R4: clk_out_o equals sqw_i while awake with sqw_sel_i high, and is 1 while awake with sqw_sel_i low. While asleep it is 0 in both cases.
- R5: While asleep with status_o equal to 2'b00, int_oe_o is 0, so the pin is three-stated.
- R6: alarm_hit_i sampled high together with alarm_en_i sets status bit 0 at that edge. alarm_hit_i with alarm_en_i low leaves status unchanged.
- R7: With sqw_sel_i high, a high-to-low change of sqw_i between two consecutive edges sets status bit 1, both awake and asleep. With sqw_sel_i low, the same change sets nothing.
- R8: Whenever status_o is nonzero, int_oe_o is 1 and int_o is 0 (pin driven low), both awake and asleep.
- R9: stat_rd_i sampled high while awake clears status_o at that edge. An interrupt event sampled at the same edge is kept.
- R10: stat_rd_i sampled high while asleep clears no status bit.
- R11: dev_reset_n_i sampled low clears status_o at that edge, even if an event arrives at the same edge. Once awake, the pin then returns to driven high.
- R12: pd_n_i sampled high while asleep returns bus_ignore_o to 0 at that edge. Pending status bits keep the pin driven low afterwards.
- R13: If pd_n_i returns high while entry is still deferred by a busy bus, the block never sets bus_ignore_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| pd_n_i | input | 1 | Power-down request, active low |
| dev_reset_n_i | input | 1 | Device reset, active low; clears status |
| alarm_hit_i | input | 1 | Alarm match pulse from the comparator |
| alarm_en_i | input | 1 | Alarm interrupt enable |
| sqw_sel_i | input | 1 | A square-wave output frequency is selected |
| sqw_i | input | 1 | Selected square wave from the divider chain |
| bus_busy_i | input | 1 | A read or write bus cycle is in progress |
| stat_rd_i | input | 1 | Status register read strobe |
| clk_out_o | output | 1 | Gated square-wave clock output |
| int_oe_o | output | 1 | Interrupt pin output enable (0 = three-stated) |
| int_o | output | 1 | Interrupt pin value when enabled (0 = active) |
| bus_ignore_o | output | 1 | Bus interface must ignore address and data inputs |
| status_o | output | 2 | Status word: bit 1 clock-edge source, bit 0 alarm source |

## Verification
Several rules are checked on every cycle: the pin is driven low whenever a status bit is pending, the pin floats when the block is asleep with nothing pending, the clock output is low while asleep, sleep is entered only from an idle bus with the request present, a high request pin ends sleep at the next edge, reads are ignored while asleep, and device reset clears status. Other behaviour needs the bench's scenarios: that entry is deferred across a multi-cycle busy window, that a request withdrawn during that window is dropped, that square-wave edges are detected only while a wave is selected, that a disabled alarm is ignored, and that a set event beats a same-edge read.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;

    localparam int SRC_W     = 2;
    localparam int SRC_ALARM = 0;
    localparam int SRC_CLOCK = 1;

    typedef enum logic [1:0] {
        PD_RUN   = 2'd0,
        PD_WAIT  = 2'd1,
        PD_SLEEP = 2'd2
    } pd_state_e;

    typedef struct packed {
        logic clk_fall;
        logic alarm;
    } int_src_t;

    function automatic pd_state_e pd_next(pd_state_e cur, logic req, logic busy);
        pd_state_e nxt;
        nxt = cur;
        case (cur)
            PD_RUN:   if (req) nxt = busy ? PD_WAIT : PD_SLEEP;
            PD_WAIT:  if (!req) nxt = PD_RUN;
                      else if (!busy) nxt = PD_SLEEP;
            PD_SLEEP: if (!req) nxt = PD_RUN;
            default:  nxt = PD_RUN;
        endcase
        return nxt;
    endfunction

    function automatic logic src_pending(int_src_t s);
        return |s;
    endfunction

endpackage

// File: rtl/rtc_pd_seq.sv
module rtc_pd_seq
    import rtc_pi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic busy,
    output logic asleep_o
);
    pd_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PD_RUN;
        else     state_q <= pd_next(state_q, pd_req, busy);
    end

    assign asleep_o = (state_q == PD_SLEEP);
endmodule

// File: rtl/rtc_fall_det.sv
module rtc_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic wave,
    input  logic sel,
    output logic fall_o
);
    logic wave_q;

    always_ff @(posedge clk) begin
        if (rst) wave_q <= 1'b0;
        else     wave_q <= wave;
    end

    assign fall_o = sel & wave_q & ~wave;
endmodule

// File: rtl/rtc_int_status.sv
module rtc_int_status
    import rtc_pi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_n,
    input  logic     alarm_set,
    input  logic     clock_set,
    input  logic     rd_clr,
    input  logic     asleep,
    output int_src_t flags_o,
    output logic     pin_oe_o,
    output logic     pin_val_o
);
    int_src_t flags_q;
    int_src_t flags_d;
    logic     pending;

    always_comb begin
        flags_d = flags_q;
        if (rd_clr && !asleep) flags_d = '0;
        if (alarm_set) flags_d.alarm    = 1'b1;
        if (clock_set) flags_d.clk_fall = 1'b1;
        if (!clr_n)    flags_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign pending   = src_pending(flags_q);
    assign flags_o   = flags_q;
    assign pin_oe_o  = asleep ? pending : 1'b1;
    assign pin_val_o = ~pending;
endmodule

// File: rtl/rtc_pwrint_ctrl.sv
module rtc_pwrint_ctrl
    import rtc_pi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_n_i,
    input  logic             dev_reset_n_i,
    input  logic             alarm_hit_i,
    input  logic             alarm_en_i,
    input  logic             sqw_sel_i,
    input  logic             sqw_i,
    input  logic             bus_busy_i,
    input  logic             stat_rd_i,
    output logic             clk_out_o,
    output logic             int_oe_o,
    output logic             int_o,
    output logic             bus_ignore_o,
    output logic [SRC_W-1:0] status_o
);
    logic     asleep;
    logic     fall;
    int_src_t flags;

    rtc_pd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .pd_req   (~pd_n_i),
        .busy     (bus_busy_i),
        .asleep_o (asleep)
    );

    rtc_fall_det u_fall (
        .clk    (clk),
        .rst    (rst),
        .wave   (sqw_i),
        .sel    (sqw_sel_i),
        .fall_o (fall)
    );

    rtc_int_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (dev_reset_n_i),
        .alarm_set (alarm_hit_i & alarm_en_i),
        .clock_set (fall),
        .rd_clr    (stat_rd_i),
        .asleep    (asleep),
        .flags_o   (flags),
        .pin_oe_o  (int_oe_o),
        .pin_val_o (int_o)
    );

    always_comb begin
        if (asleep)         clk_out_o = 1'b0;
        else if (sqw_sel_i) clk_out_o = sqw_i;
        else                clk_out_o = 1'b1;
    end

    assign bus_ignore_o = asleep;
    assign status_o     = flags;
endmodule

// File: rtl/rtc_pwrint_ctrl_chk.sv
module rtc_pwrint_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pd_n_i,
    input logic       dev_reset_n_i,
    input logic       bus_busy_i,
    input logic       stat_rd_i,
    input logic       clk_out_o,
    input logic       int_oe_o,
    input logic       int_o,
    input logic       bus_ignore_o,
    input logic [1:0] status_o
);
    AST_SLEEP_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        bus_ignore_o |-> !clk_out_o); // R4

    AST_SLEEP_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ignore_o) |-> ($past(!bus_busy_i) && $past(!pd_n_i))); // R3

    AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (bus_ignore_o && pd_n_i) |=> !bus_ignore_o); // R12

    AST_PEND_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        (status_o != 2'b00) |-> (int_oe_o && !int_o)); // R8

    AST_SLEEP_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (bus_ignore_o && status_o == 2'b00) |-> !int_oe_o); // R5

    AST_SLEEP_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_ignore_o && stat_rd_i && dev_reset_n_i) |=>
        ((status_o & $past(status_o)) == $past(status_o))); // R10

    AST_DEVRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !dev_reset_n_i |=> (status_o == 2'b00)); // R11
endmodule

bind rtc_pwrint_ctrl rtc_pwrint_ctrl_chk u_chk (.*);

// File: tb/rtc_pwrint_ctrl_tb.sv
module rtc_pwrint_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_n_i = 1'b1;
    logic       dev_reset_n_i = 1'b1;
    logic       alarm_hit_i = 1'b0;
    logic       alarm_en_i = 1'b1;
    logic       sqw_sel_i = 1'b0;
    logic       sqw_i = 1'b0;
    logic       bus_busy_i = 1'b0;
    logic       stat_rd_i = 1'b0;
    logic       clk_out_o;
    logic       int_oe_o;
    logic       int_o;
    logic       bus_ignore_o;
    logic [1:0] status_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] st;
        logic       oe;
        logic       iv;
        logic       co;
        logic       ig;
    } exp_item_t;

    exp_item_t sb_q[$];
    exp_item_t it;

    always #2 clk = ~clk;

    rtc_pwrint_ctrl u_dut (
        .clk           (clk),
        .rst           (rst),
        .pd_n_i        (pd_n_i),
        .dev_reset_n_i (dev_reset_n_i),
        .alarm_hit_i   (alarm_hit_i),
        .alarm_en_i    (alarm_en_i),
        .sqw_sel_i     (sqw_sel_i),
        .sqw_i         (sqw_i),
        .bus_busy_i    (bus_busy_i),
        .stat_rd_i     (stat_rd_i),
        .clk_out_o     (clk_out_o),
        .int_oe_o      (int_oe_o),
        .int_o         (int_o),
        .bus_ignore_o  (bus_ignore_o),
        .status_o      (status_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_exp(string tag, logic [1:0] st, logic oe, logic iv,
                            logic co, logic ig);
        exp_item_t e;
        e.tag = tag; e.st = st; e.oe = oe; e.iv = iv; e.co = co; e.ig = ig;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (status_o !== it.st || int_oe_o !== it.oe || int_o !== it.iv ||
                clk_out_o !== it.co || bus_ignore_o !== it.ig) begin
                failures++;
                $display("FAIL %s: got st=%b oe=%b int=%b clk=%b ign=%b exp st=%b oe=%b int=%b clk=%b ign=%b",
                         it.tag, status_o, int_oe_o, int_o, clk_out_o, bus_ignore_o,
                         it.st, it.oe, it.iv, it.co, it.ig);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        push_exp("R1 reset state", 2'b00, 1, 1, 1, 0);
        // R4: selected wave passes through while awake
        tick(); sqw_sel_i = 1; sqw_i = 1; push_exp("R4 wave high", 2'b00, 1, 1, 1, 0);
        tick(); sqw_i = 0;                push_exp("R4 wave low",  2'b00, 1, 1, 0, 0);
        tick(); stat_rd_i = 1;            push_exp("R7 fall sets bit1 / R8", 2'b10, 1, 0, 0, 0);
        tick(); stat_rd_i = 0;            push_exp("R9 read clears", 2'b00, 1, 1, 0, 0);
        // R7: no edge detection when unselected
        tick(); sqw_sel_i = 0; sqw_i = 1; push_exp("R4 unselected high", 2'b00, 1, 1, 1, 0);
        tick(); sqw_i = 0;                push_exp("R4 unselected stays high", 2'b00, 1, 1, 1, 0);
        tick();                           push_exp("R7 unselected fall ignored", 2'b00, 1, 1, 1, 0);
        // R6: alarm enable gating
        tick(); alarm_en_i = 0; alarm_hit_i = 1; push_exp("R6 pre", 2'b00, 1, 1, 1, 0);
        tick(); alarm_hit_i = 0; alarm_en_i = 1; push_exp("R6 disabled alarm ignored", 2'b00, 1, 1, 1, 0);
        tick(); alarm_hit_i = 1;          push_exp("R6 pre2", 2'b00, 1, 1, 1, 0);
        tick(); alarm_hit_i = 0;          push_exp("R6 alarm sets bit0 / R8", 2'b01, 1, 0, 1, 0);
        tick(); stat_rd_i = 1;            push_exp("R9 pre", 2'b01, 1, 0, 1, 0);
        tick(); stat_rd_i = 0;            push_exp("R9 read clears alarm", 2'b00, 1, 1, 1, 0);
        // R9: same-edge set wins over read clear
        tick(); stat_rd_i = 1; alarm_hit_i = 1; push_exp("R9 pre3", 2'b00, 1, 1, 1, 0);
        tick(); stat_rd_i = 0; alarm_hit_i = 0; push_exp("R9 set beats read", 2'b01, 1, 0, 1, 0);
        // R11: device reset clears, beats same-edge event
        tick(); dev_reset_n_i = 0; alarm_hit_i = 1; push_exp("R11 pre", 2'b01, 1, 0, 1, 0);
        tick(); dev_reset_n_i = 1; alarm_hit_i = 0; push_exp("R11 device reset clears", 2'b00, 1, 1, 1, 0);
        // R2: sleep entry from idle bus
        tick(); pd_n_i = 0;               push_exp("R2 not yet asleep", 2'b00, 1, 1, 1, 0);
        tick();                           push_exp("R2 asleep / R5 float / R4 low", 2'b00, 0, 1, 0, 1);
        tick(); alarm_hit_i = 1;          push_exp("R5 still float", 2'b00, 0, 1, 0, 1);
        tick(); alarm_hit_i = 0;          push_exp("R8 alarm drives low asleep", 2'b01, 1, 0, 0, 1);
        tick(); stat_rd_i = 1;            push_exp("R10 pre", 2'b01, 1, 0, 0, 1);
        tick(); stat_rd_i = 0;            push_exp("R10 read ignored asleep", 2'b01, 1, 0, 0, 1);
        tick(); sqw_sel_i = 1; sqw_i = 1; push_exp("R4 wave high but asleep", 2'b01, 1, 0, 0, 1);
        tick(); sqw_i = 0;                push_exp("R7 pre asleep", 2'b01, 1, 0, 0, 1);
        tick();                           push_exp("R7 fall sets bit1 asleep", 2'b11, 1, 0, 0, 1);
        // R12: wake with pending status
        tick(); pd_n_i = 1;               push_exp("R12 still asleep", 2'b11, 1, 0, 0, 1);
        tick(); sqw_sel_i = 0;            push_exp("R12 awake, pending keeps low", 2'b11, 1, 0, 1, 0);
        tick(); stat_rd_i = 1;            push_exp("R9 pre4", 2'b11, 1, 0, 1, 0);
        tick(); stat_rd_i = 0;            push_exp("R9 read clears both", 2'b00, 1, 1, 1, 0);
        // R3: deferred entry across busy bus
        tick(); bus_busy_i = 1; pd_n_i = 0; push_exp("R3 req during busy", 2'b00, 1, 1, 1, 0);
        for (int k = 0; k < 3; k++) begin
            tick();                       push_exp("R3 deferred while busy", 2'b00, 1, 1, 1, 0);
        end
        tick(); bus_busy_i = 0;           push_exp("R3 busy ends", 2'b00, 1, 1, 1, 0);
        tick();                           push_exp("R3 entered after cycle", 2'b00, 0, 1, 0, 1);
        tick(); pd_n_i = 1;               push_exp("R12 exit pre", 2'b00, 0, 1, 0, 1);
        tick();                           push_exp("R12 exit", 2'b00, 1, 1, 1, 0);
        // R13: withdrawn request while deferred
        tick(); bus_busy_i = 1; pd_n_i = 0; push_exp("R13 pre", 2'b00, 1, 1, 1, 0);
        tick();                           push_exp("R13 deferred", 2'b00, 1, 1, 1, 0);
        tick(); pd_n_i = 1;               push_exp("R13 withdraw", 2'b00, 1, 1, 1, 0);
        tick(); bus_busy_i = 0;           push_exp("R13 busy ends", 2'b00, 1, 1, 1, 0);
        tick();                           push_exp("R13 never sleeps", 2'b00, 1, 1, 1, 0);
        tick();                           push_exp("R13 never sleeps 2", 2'b00, 1, 1, 1, 0);
        tick();
        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule